// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous EDO DRAM from power-on to a usable state and then keeps its contents alive. After reset it holds every strobe inactive for a programmable pause. It then runs a burst of wake-up cycles on its own, and only after those does it raise a ready flag to the access controller. From then on an interval timer creates one refresh slot per period. Each slot is sized so that every row is covered within the retention window: 512 refreshes per 8 ms, or about one every 15.6 µs.

Refresh cycles use the column-before-row ordering. Both column strobes fall while the row strobe is high and stay low through a setup window. The row strobe then falls, and the column strobes rise again after a hold window. The memory's internal row counter supplies the row, so no address, write-enable or output-enable pin is involved. Once the memory is ready, the sequencer may only drive the strobes after the access controller grants them. It asks through a request line and holds that line high for as long as it wants or owns the pins. Slots that wait for a grant pile up in a small backlog counter, and an urgent flag tells the controller to close an open page. If the backlog overflows, the retention window counts as lost: ready falls, the backlog is dropped, and the wake-up burst is repeated under grant.

All intervals are given in clock cycles as parameters. The defaults assume a 100 MHz clock.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, rasN, casLoN and casHiN are high and memReady, refReq and refUrgent are low.
- R2: After reset is released, no strobe goes low for at least PAUSE_CYCLES clock cycles, and memReady stays low.
- R3: After the pause, exactly WAKE_COUNT refresh cycles run without any grant. memReady rises after the last of them.
- R4: In every refresh cycle, both column strobes fall together while rasN is high. They stay low for exactly SETUP_CYCLES cycles before rasN falls, and stay low for exactly HOLD_CYCLES cycles after it, rising while rasN is still low. A column strobe never falls while rasN is low.
- R5: Each rasN low pulse lasts exactly RAS_LOW_CYCLES cycles. rasN stays high for at least PRECHARGE_CYCLES cycles between pulses.
- R6: Once memReady is high, one refresh slot is created every INTERVAL_CYCLES cycles. With refGrant held high, the refresh rate matches that interval.
- R7: Once memReady has been high, a refresh cycle starts only while refGrant is high. refReq is high whenever a slot is waiting or a cycle is running, and all strobes stay high while refReq is low.
- R8: refUrgent is high while the backlog holds at least URGENT_LEVEL slots.
- R9: When granted, all waiting slots are serviced back to back, one cycle per slot, and refReq then falls.
- R10: A slot that arrives while PENDING_MAX slots are already waiting drops memReady and clears the backlog. WAKE_COUNT granted cycles then run before memReady returns high.
- R11: A grant with no slot waiting starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset, applied at power-on |
| refGrant | input | 1 | Access controller hands the strobe pins to the sequencer |
| refReq | output | 1 | Sequencer wants or owns the strobe pins |
| refUrgent | output | 1 | Backlog has reached the urgent level |
| memReady | output | 1 | Memory is initialised and holds valid data |
| rasN | output | 1 | Row strobe to the memory, active low |
| casLoN | output | 1 | Lower-byte column strobe, active low |
| casHiN | output | 1 | Upper-byte column strobe, active low |

## Verification
A stuck or miscounted phase counter shows at once in the strobe waveform. Within the same refresh cycle the setup, hold or row-low width comes out wrong, or a row strobe falls without a column strobe already low. A wrong backlog or wake-up counter shows later. It appears as too few or too many row pulses when a withheld grant is released, as an urgent flag at the wrong depth, or as memReady rising after a different number of wake-up pulses. An interval timer fault shows as a drifting refresh rate over a few intervals.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_PRE
  } seqState_t;

  // phase selector values for the shared phase timer
  localparam logic [1:0] PH_SETUP  = 2'd0;
  localparam logic [1:0] PH_ACTIVE = 2'd1;
  localparam logic [1:0] PH_PRE    = 2'd2;

  typedef struct packed {
    logic       pauseRun;
    logic       phaseClr;
    logic [1:0] phaseSel;
    logic       launch;
    logic       finish;
  } seqCtl_t;

  typedef struct packed {
    logic pauseDone;
    logic phaseDone;
    logic holdOver;
    logic work;
    logic everReady;
    logic ready;
  } seqStat_t;

endpackage

// File: rtl/dram_refresh_dp.sv
module dram_refresh_dp
  import dram_refresh_pkg::*;
#(
  parameter int PAUSE_CYCLES     = 20000,
  parameter int WAKE_COUNT       = 8,
  parameter int INTERVAL_CYCLES  = 1562,
  parameter int SETUP_CYCLES     = 2,
  parameter int HOLD_CYCLES      = 2,
  parameter int RAS_LOW_CYCLES   = 6,
  parameter int PRECHARGE_CYCLES = 4,
  parameter int PENDING_MAX      = 7,
  parameter int URGENT_LEVEL     = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  seqCtl_t  ctl,
  output seqStat_t stat,
  output logic     urgent
);

  localparam int PAUSE_W = $clog2(PAUSE_CYCLES + 1);
  localparam int INT_W   = $clog2(INTERVAL_CYCLES + 1);
  localparam int WAKE_W  = $clog2(WAKE_COUNT + 1);
  localparam int PEND_W  = $clog2(PENDING_MAX + 1);
  localparam int PH_MAX  = (RAS_LOW_CYCLES > SETUP_CYCLES)
                         ? ((RAS_LOW_CYCLES > PRECHARGE_CYCLES) ? RAS_LOW_CYCLES : PRECHARGE_CYCLES)
                         : ((SETUP_CYCLES > PRECHARGE_CYCLES) ? SETUP_CYCLES : PRECHARGE_CYCLES);
  localparam int PH_W    = $clog2(PH_MAX + 1);

  logic [PAUSE_W-1:0] pauseCnt;
  logic [INT_W-1:0]   intervalCnt;
  logic [WAKE_W-1:0]  wakeLeft;
  logic [PEND_W-1:0]  pending;
  logic [PH_W-1:0]    phaseCnt;
  logic [PH_W-1:0]    phaseLimit;
  logic               ready;
  logic               everReady;
  logic               tick;
  logic               consume;
  logic               overflow;

  // power-on pause timer
  always_ff @(posedge clk) begin
    if (!rstN)             pauseCnt <= '0;
    else if (ctl.pauseRun) pauseCnt <= pauseCnt + 1'b1;
  end

  // shared phase timer for setup, row-low and precharge windows
  always_comb begin
    case (ctl.phaseSel)
      PH_SETUP:  phaseLimit = PH_W'(SETUP_CYCLES - 1);
      PH_ACTIVE: phaseLimit = PH_W'(RAS_LOW_CYCLES - 1);
      default:   phaseLimit = PH_W'(PRECHARGE_CYCLES - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.phaseClr) phaseCnt <= '0;
    else                       phaseCnt <= phaseCnt + 1'b1;
  end

  // refresh slot timer, runs only while the memory is ready
  assign tick = ready && (intervalCnt == INT_W'(INTERVAL_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rstN || !ready || tick) intervalCnt <= '0;
    else                         intervalCnt <= intervalCnt + 1'b1;
  end

  // a launched cycle serves the wake burst first, then the backlog
  assign consume  = ctl.launch && (wakeLeft == '0);
  assign overflow = tick && (pending == PEND_W'(PENDING_MAX)) && !consume;

  always_ff @(posedge clk) begin
    if (!rstN)                                wakeLeft <= WAKE_W'(WAKE_COUNT);
    else if (overflow)                        wakeLeft <= WAKE_W'(WAKE_COUNT);
    else if (ctl.launch && wakeLeft != '0)    wakeLeft <= wakeLeft - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || overflow) pending <= '0;
    else begin
      case ({tick, consume && (pending != '0)})
        2'b10:   pending <= pending + 1'b1;
        2'b01:   pending <= pending - 1'b1;
        default: pending <= pending;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || overflow)                     ready <= 1'b0;
    else if (ctl.finish && wakeLeft == '0)     ready <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)      everReady <= 1'b0;
    else if (ready) everReady <= 1'b1;
  end

  assign urgent = (pending >= PEND_W'(URGENT_LEVEL));

  always_comb begin
    stat.pauseDone = (pauseCnt == PAUSE_W'(PAUSE_CYCLES - 1));
    stat.phaseDone = (phaseCnt == phaseLimit);
    stat.holdOver  = (phaseCnt >= PH_W'(HOLD_CYCLES));
    stat.work      = (wakeLeft != '0) || (pending != '0);
    stat.everReady = everReady;
    stat.ready     = ready;
  end

endmodule

// File: rtl/dram_refresh_ctl.sv
module dram_refresh_ctl
  import dram_refresh_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     refGrant,
  input  seqStat_t stat,
  output seqCtl_t  ctl,
  output logic     rasN,
  output logic     casN,
  output logic     refReq
);

  seqState_t state;
  seqState_t nxt;
  logic      launch;

  assign launch = (state == ST_IDLE) && stat.work && (refGrant || !stat.everReady);

  always_comb begin
    nxt = state;
    case (state)
      ST_PAUSE:  if (stat.pauseDone) nxt = ST_IDLE;
      ST_IDLE:   if (launch)         nxt = ST_SETUP;
      ST_SETUP:  if (stat.phaseDone) nxt = ST_ACTIVE;
      ST_ACTIVE: if (stat.phaseDone) nxt = ST_PRE;
      ST_PRE:    if (stat.phaseDone) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_PAUSE;
    else       state <= nxt;
  end

  always_comb begin
    ctl.pauseRun = (state == ST_PAUSE);
    ctl.phaseClr = (nxt != state);
    ctl.launch   = launch;
    ctl.finish   = (state == ST_PRE) && stat.phaseDone;
    case (state)
      ST_ACTIVE: ctl.phaseSel = PH_ACTIVE;
      ST_PRE:    ctl.phaseSel = PH_PRE;
      default:   ctl.phaseSel = PH_SETUP;
    endcase
  end

  assign rasN   = (state != ST_ACTIVE);
  assign casN   = !((state == ST_SETUP) || ((state == ST_ACTIVE) && !stat.holdOver));
  assign refReq = ((state == ST_IDLE) && stat.work) ||
                  (state == ST_SETUP) || (state == ST_ACTIVE) || (state == ST_PRE);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int PAUSE_CYCLES     = 20000,
  parameter int WAKE_COUNT       = 8,
  parameter int INTERVAL_CYCLES  = 1562,
  parameter int SETUP_CYCLES     = 2,
  parameter int HOLD_CYCLES      = 2,
  parameter int RAS_LOW_CYCLES   = 6,
  parameter int PRECHARGE_CYCLES = 4,
  parameter int PENDING_MAX      = 7,
  parameter int URGENT_LEVEL     = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGrant,
  output logic refReq,
  output logic refUrgent,
  output logic memReady,
  output logic rasN,
  output logic casLoN,
  output logic casHiN
);

  seqCtl_t  ctl;
  seqStat_t stat;
  logic     casN;

  dram_refresh_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .refGrant (refGrant),
    .stat     (stat),
    .ctl      (ctl),
    .rasN     (rasN),
    .casN     (casN),
    .refReq   (refReq)
  );

  dram_refresh_dp #(
    .PAUSE_CYCLES     (PAUSE_CYCLES),
    .WAKE_COUNT       (WAKE_COUNT),
    .INTERVAL_CYCLES  (INTERVAL_CYCLES),
    .SETUP_CYCLES     (SETUP_CYCLES),
    .HOLD_CYCLES      (HOLD_CYCLES),
    .RAS_LOW_CYCLES   (RAS_LOW_CYCLES),
    .PRECHARGE_CYCLES (PRECHARGE_CYCLES),
    .PENDING_MAX      (PENDING_MAX),
    .URGENT_LEVEL     (URGENT_LEVEL)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .stat   (stat),
    .urgent (refUrgent)
  );

  assign memReady = stat.ready;
  // both byte lanes take part in every refresh cycle
  assign casLoN   = casN;
  assign casHiN   = casN;

endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int RAS_LOW_CYCLES = 6
) (
  input logic clk,
  input logic rstN,
  input logic refReq,
  input logic refUrgent,
  input logic memReady,
  input logic rasN,
  input logic casLoN,
  input logic casHiN
);

  int lowRun;

  always_ff @(posedge clk) begin
    if (!rstN)     lowRun <= 0;
    else if (!rasN) lowRun <= lowRun + 1;
    else           lowRun <= 0;
  end

  assert_cbr_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!casLoN && !casHiN));

  assert_cas_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casLoN) |-> rasN);

  assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (lowRun == RAS_LOW_CYCLES));

  assert_quiet_pins_R7: assert property (@(posedge clk) disable iff (!rstN)
    !refReq |-> (rasN && casLoN && casHiN));

  assert_urgent_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    refUrgent |-> refReq);

  assert_rewake_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memReady) |-> refReq);

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .RAS_LOW_CYCLES (RAS_LOW_CYCLES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .refReq    (refReq),
  .refUrgent (refUrgent),
  .memReady  (memReady),
  .rasN      (rasN),
  .casLoN    (casLoN),
  .casHiN    (casHiN)
);

// File: tb/dram_refresh_seq_tb.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb;

  localparam int PAUSE    = 50;
  localparam int WAKE     = 8;
  localparam int INTERVAL = 60;
  localparam int SETUP    = 2;
  localparam int HOLD     = 2;
  localparam int RASLOW   = 5;
  localparam int PRE      = 3;
  localparam int PMAX     = 3;
  localparam int URG      = 2;
  localparam int WATCHDOG = 20000;

  // grant delay after request, expected urgent at grant, expected cycles
  localparam int NVEC = 4;
  localparam int VEC [NVEC][3] = '{'{5, 0, 1}, '{30, 0, 1}, '{65, 1, 2}, '{75, 1, 2}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGrant = 1'b0;
  logic refReq, refUrgent, memReady, rasN, casLoN, casHiN;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int rasFalls = 0;
  bit everReadySeen = 0;
  bit doneFlag = 0;

  always #5 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYCLES (PAUSE), .WAKE_COUNT (WAKE), .INTERVAL_CYCLES (INTERVAL),
    .SETUP_CYCLES (SETUP), .HOLD_CYCLES (HOLD), .RAS_LOW_CYCLES (RASLOW),
    .PRECHARGE_CYCLES (PRE), .PENDING_MAX (PMAX), .URGENT_LEVEL (URG)
  ) u_dut (
    .clk (clk), .rstN (rstN), .refGrant (refGrant), .refReq (refReq),
    .refUrgent (refUrgent), .memReady (memReady), .rasN (rasN),
    .casLoN (casLoN), .casHiN (casHiN)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // waveform monitor: sampled on the falling clock edge
  logic prevRas = 1'b1, prevCas = 1'b1;
  int setupRun = 0, holdRun = 0, lowRun = 0, highRun = 0;

  always @(negedge clk) begin
    cycles++;
    if (memReady) everReadySeen = 1;
    if (rstN) begin
      if (prevRas && !rasN) begin
        chk(!casLoN && !casHiN, "R4", "both column strobes low at row fall",
            {casLoN, casHiN}, 0);
        chk(setupRun == SETUP, "R4", "column setup before row fall", setupRun, SETUP);
        if (rasFalls > 0)
          chk(highRun >= PRE, "R5", "row precharge width", highRun, PRE);
        if (everReadySeen)
          chk(refGrant, "R7", "row fall only under grant", refGrant, 1);
        rasFalls++;
        lowRun = 1;
        holdRun = casLoN ? 0 : 1;
      end else if (!rasN) begin
        lowRun++;
        if (!casLoN) holdRun++;
      end
      if (!prevCas && casLoN && !rasN)
        chk(holdRun == HOLD, "R4", "column hold after row fall", holdRun, HOLD);
      if (!prevRas && rasN) begin
        chk(lowRun == RASLOW, "R5", "row low pulse width", lowRun, RASLOW);
        highRun = 1;
      end else if (rasN) highRun++;
      if (rasN && !casLoN) setupRun++;
      else if (rasN) setupRun = 0;
    end
    prevRas = rasN;
    prevCas = casLoN;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    chk(0, "WATCHDOG", "run did not finish", cycles, WATCHDOG);
    summary();
  end

  initial begin
    int n;
    int base;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(rasN && casLoN && casHiN, "R1", "strobes high in reset", {rasN, casLoN, casHiN}, 7);
    chk(!memReady && !refReq && !refUrgent, "R1", "flags low in reset",
        {memReady, refReq, refUrgent}, 0);
    @(posedge clk); #2 rstN = 1'b1;

    // R2 pause length, no grant given
    n = 0;
    while (casLoN && n < 1000) begin
      @(negedge clk); n++;
      if (memReady) break;
    end
    chk(n >= PAUSE && n <= PAUSE + 3, "R2", "cycles before first column strobe", n, PAUSE + 2);
    chk(rasFalls == 0, "R2", "no row pulse during pause", rasFalls, 0);

    // R3 wake-up burst without grant
    n = 0;
    while (!memReady && n < 1000) begin @(negedge clk); n++; end
    chk(memReady, "R3", "ready after wake burst", memReady, 1);
    chk(rasFalls == WAKE, "R3", "wake pulses before ready", rasFalls, WAKE);

    // vector table: grant withheld for a while, then given
    for (int v = 0; v < NVEC; v++) begin
      n = 0;
      while (!refReq && n < 200) begin @(negedge clk); n++; end
      chk(refReq, "R6", "slot request appears", refReq, 1);
      base = rasFalls;
      repeat (VEC[v][0]) @(negedge clk);
      chk(rasFalls == base, "R7", "no cycle without grant", rasFalls - base, 0);
      chk(refUrgent == VEC[v][1], "R8", "urgent at backlog depth", refUrgent, VEC[v][1]);
      @(posedge clk); #2 refGrant = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (refReq && n < 200);
      chk(!refReq, "R9", "request drops after backlog drained", refReq, 0);
      chk(rasFalls - base == VEC[v][2], "R9", "cycles serviced for backlog",
          rasFalls - base, VEC[v][2]);
      @(posedge clk); #2 refGrant = 1'b0;
    end

    // R11: grant with nothing waiting starts nothing
    @(posedge clk); #2 refGrant = 1'b1;
    n = 0;
    while (!refReq && n < 200) begin @(negedge clk); n++; end
    n = 0;
    while (refReq && n < 200) begin @(negedge clk); n++; end
    base = rasFalls;
    repeat (30) @(negedge clk);
    chk(rasFalls == base && !refReq, "R11", "idle grant causes no cycle", rasFalls - base, 0);

    // R6 rate with grant held high
    base = rasFalls;
    repeat (10 * INTERVAL) @(negedge clk);
    chk(rasFalls - base >= 9 && rasFalls - base <= 11, "R6", "refreshes in ten intervals",
        rasFalls - base, 10);

    // R10 backlog overflow and re-wake
    @(posedge clk); #2 refGrant = 1'b0;
    base = rasFalls;
    n = 0;
    while (memReady && n < 400) begin @(negedge clk); n++; end
    chk(!memReady, "R10", "ready drops on overflow", memReady, 0);
    chk(refReq, "R10", "request held for re-wake", refReq, 1);
    chk(!refUrgent, "R10", "backlog cleared on overflow", refUrgent, 0);
    chk(rasFalls == base, "R7", "no cycle while grant withheld", rasFalls - base, 0);
    @(posedge clk); #2 refGrant = 1'b1;
    n = 0;
    while (!memReady && n < 1000) begin @(negedge clk); n++; end
    chk(memReady, "R10", "ready returns after re-wake", memReady, 1);
    chk(rasFalls - base == WAKE, "R10", "re-wake pulse count", rasFalls - base, WAKE);

    repeat (5) @(negedge clk);
    summary();
  end

endmodule